// File: doc/BRIEF.md
# SMI/SCI Event Aggregation Controller

This block gathers a set of power-management and security event lines and turns them into two requests for the host: a level-mode SCI interrupt line and a one-cycle SMI message pulse. Each event has a sticky status bit and an enable bit. A routing select decides whether events that can go either way feed the SCI line or the SMI request. Some sources are fixed to one output. One source is a release event that always drives SCI.

SMI delivery is throttled by an end-of-SMI handshake. The SMI state machine has three states. `SMI_ARMED` means the end-of-SMI bit reads 1. `SMI_SEND` drives the one-cycle message and clears the bit. `SMI_WAIT` holds until software writes 1 to the bit. Its transitions are:
- ARMED to SEND when an enabled SMI status is pending.
- SEND to WAIT unconditionally.
- WAIT to ARMED on a software re-arm. If events are still pending, ARMED then goes straight on to SEND, so a re-arm with pending events produces a new message.

One extra external SCI request input reaches its status bit only after a minimum-width qualifier. The qualifier's length is derived from the clock frequency parameter.

Top module: `smi_sci_aggregator`

## Requirements
- R1: With the global SMI enable set and the end-of-SMI bit at 1, any status bit that is set, enabled and routed to SMI causes exactly one SMI message. The message is a single-cycle pulse on `smi_msg`, and the end-of-SMI bit (control register bit 2) then reads 0.
- R2: While the end-of-SMI bit is 0, newly set SMI statuses produce no SMI message.
- R3: A write of 1 to control bit 2 re-arms delivery. If an enabled SMI status is still set, one new SMI message follows and the bit reads 0 again. If none is set, no message follows and the bit reads 1.
- R4: `sci_out` is a level. It stays 1 until every status bit that is set, enabled and routed to SCI has been cleared.
- R5: Dual-route sources go to SCI when control bit 0 (route select) is 1 and to SMI when it is 0. With default parameters these are bits 4 to 7, plus bit 8, the qualified external request.
- R6: No SMI message is produced while control bit 1 (global SMI enable) is 0.
- R7: The release source (bit 1 by default) raises `sci_out` even when route select is 0.
- R8: SCI-only sources (bit 0 by default) never raise SMI, and they raise SCI only when route select is 1. SMI-only sources (bits 2 and 3 by default) never raise SCI.
- R9: The external request sets status bit 8 only after it has been held high for `CLK_KHZ/10` consecutive clock edges, which is 100 microseconds. Shorter pulses leave the status and `sci_out` unchanged.
- R10: A status bit sets on the rising edge of its source. It clears only when software writes 1 to that bit at register address 0. If a set and a clear of the same bit happen in one cycle, the bit ends up set.
- R11: The register map is: address 0 holds status, address 1 holds enables, and address 2 holds control. Reset clears status, enables, route select and global enable, and sets the end-of-SMI bit to 1. Both outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | NUM_SRC | Raw event source levels |
| ext_sci_req | input | 1 | External SCI request, width-qualified |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | NUM_SRC+1 | Write data |
| reg_rdata | output | NUM_SRC+1 | Read data of the selected register |
| sci_out | output | 1 | Level SCI request |
| smi_msg | output | 1 | One-cycle SMI message |

## Verification
The bench builds the block with eight sources and `CLK_KHZ` = 200, so the qualifier window is 20 cycles. This short window lets the bench test both the 19-edge pulse that must be rejected and a held request that must be accepted, without long waits. The default route masks cover all four source kinds (SCI-only, release, SMI-only and dual), so a single table can walk every routing case and the end-of-SMI handshake.

// File: rtl/smi_sci_pkg.sv
package smi_sci_pkg;
    typedef enum logic [1:0] {
        REG_STS = 2'd0,
        REG_EN  = 2'd1,
        REG_CTL = 2'd2
    } reg_sel_e;

    typedef enum logic [1:0] {
        SMI_ARMED = 2'd0,
        SMI_SEND  = 2'd1,
        SMI_WAIT  = 2'd2
    } smi_state_e;

    localparam int CTL_ROUTE = 0;
    localparam int CTL_GLB   = 1;
    localparam int CTL_EOS   = 2;
endpackage

// File: rtl/sci_req_qualifier.sv
module sci_req_qualifier #(
    parameter int QUAL_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic qual
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);

    logic [CW-1:0] cnt;

    // Count consecutive high cycles, saturate at the limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!req) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = (cnt == LIMIT);
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status
);
    logic [W-1:0] src_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[i]  <= 1'b0;
                status[i] <= 1'b0;
            end else begin
                src_q[i] <= src[i];
                // A rising edge wins over a same-cycle clear.
                if (src[i] && !src_q[i]) begin
                    status[i] <= 1'b1;
                end else if (clr[i]) begin
                    status[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/smi_delivery_fsm.sv
module smi_delivery_fsm
    import smi_sci_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic rearm,
    output logic smi_msg,
    output logic eos
);
    smi_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SMI_ARMED;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SMI_ARMED: if (pending) state_nx = SMI_SEND;
            SMI_SEND:  state_nx = SMI_WAIT;
            SMI_WAIT:  if (rearm) state_nx = SMI_ARMED;
            default:   state_nx = SMI_ARMED;
        endcase
    end

    always_comb begin
        smi_msg = 1'b0;
        eos     = 1'b0;
        unique case (state)
            SMI_ARMED: eos = 1'b1;
            SMI_SEND:  smi_msg = 1'b1;
            SMI_WAIT:  eos = 1'b0;
            default:   eos = 1'b0;
        endcase
    end
endmodule

// File: rtl/smi_sci_aggregator.sv
module smi_sci_aggregator
    import smi_sci_pkg::*;
#(
    parameter int              NUM_SRC       = 8,
    parameter int              CLK_KHZ       = 100000,
    parameter logic [NUM_SRC-1:0] SCI_ONLY_MASK = 8'h01,
    parameter logic [NUM_SRC-1:0] FORCE_SCI_MASK = 8'h02,
    parameter logic [NUM_SRC-1:0] SMI_ONLY_MASK = 8'h0C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               ext_sci_req,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC:0]   reg_wdata,
    output logic [NUM_SRC:0]   reg_rdata,
    output logic               sci_out,
    output logic               smi_msg
);
    localparam int W        = NUM_SRC + 1;
    localparam int QUAL_CYC = (CLK_KHZ / 10 < 1) ? 1 : CLK_KHZ / 10;

    logic [W-1:0] status, en_q, src_all, clr_v;
    logic [W-1:0] sci_rt, smi_rt;
    logic         route_q, glb_q, eos, ext_qual, rearm;
    logic         smi_pending, sci_active;

    sci_req_qualifier #(.QUAL_CYC(QUAL_CYC)) u_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (ext_sci_req),
        .qual (ext_qual)
    );

    assign src_all = {ext_qual, evt_in};
    assign clr_v   = (reg_wr && reg_addr == REG_STS) ? reg_wdata : '0;

    evt_status_bank #(.W(W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_all),
        .clr   (clr_v),
        .status(status)
    );

    // Per-source routing; the external request is a dual-route source.
    for (genvar i = 0; i < W; i++) begin : g_route
        if (i == NUM_SRC) begin : g_ext
            assign sci_rt[i] = route_q;
            assign smi_rt[i] = !route_q;
        end else begin : g_evt
            localparam bit FORCE = FORCE_SCI_MASK[i];
            localparam bit SCIO  = SCI_ONLY_MASK[i];
            localparam bit SMIO  = SMI_ONLY_MASK[i];
            localparam bit DUAL  = !(FORCE || SCIO || SMIO);
            assign sci_rt[i] = FORCE || (route_q && (SCIO || DUAL));
            assign smi_rt[i] = SMIO || (DUAL && !route_q);
        end
    end

    assign smi_pending = glb_q && |(status & en_q & smi_rt);
    assign sci_active  = |(status & en_q & sci_rt);
    assign rearm       = reg_wr && reg_addr == REG_CTL && reg_wdata[CTL_EOS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= 1'b0;
            glb_q   <= 1'b0;
            sci_out <= 1'b0;
        end else begin
            sci_out <= sci_active;
            if (reg_wr && reg_addr == REG_EN) begin
                en_q <= reg_wdata;
            end
            if (reg_wr && reg_addr == REG_CTL) begin
                route_q <= reg_wdata[CTL_ROUTE];
                glb_q   <= reg_wdata[CTL_GLB];
            end
        end
    end

    smi_delivery_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pending(smi_pending),
        .rearm  (rearm),
        .smi_msg(smi_msg),
        .eos    (eos)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_STS: reg_rdata = status;
            REG_EN:  reg_rdata = en_q;
            REG_CTL: begin
                reg_rdata[CTL_ROUTE] = route_q;
                reg_rdata[CTL_GLB]   = glb_q;
                reg_rdata[CTL_EOS]   = eos;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/smi_sci_checker.sv
module smi_sci_checker #(
    parameter int W        = 9,
    parameter int QUAL_CYC = 10000
) (
    input logic         clk,
    input logic         rst_n,
    input logic         smi_msg,
    input logic         sci_out,
    input logic         eos,
    input logic         glb_q,
    input logic         ext_sci_req,
    input logic         ext_qual,
    input logic [W-1:0] status,
    input logic         reg_wr,
    input logic [1:0]   reg_addr
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run <= '0;
        else if (!ext_sci_req) run <= '0;
        else if (run != CW'(QUAL_CYC)) run <= run + 1'b1;
    end

    AST_SMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) smi_msg |=> !smi_msg); // R1
    AST_SMI_CLEARS_EOS: assert property (@(posedge clk) disable iff (!rst_n) smi_msg |-> !eos); // R1
    AST_NO_SMI_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n) smi_msg |-> $past(eos)); // R2
    AST_SMI_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n) smi_msg |-> $past(glb_q)); // R6
    AST_SCI_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) sci_out |-> $past(status != '0)); // R4
    AST_QUAL_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) ext_qual |-> run == CW'(QUAL_CYC)); // R9
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 2'd0) |=> ((status & $past(status)) == $past(status))); // R10
endmodule

bind smi_sci_aggregator smi_sci_checker #(.W(W), .QUAL_CYC(QUAL_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smi_msg    (smi_msg),
    .sci_out    (sci_out),
    .eos        (eos),
    .glb_q      (glb_q),
    .ext_sci_req(ext_sci_req),
    .ext_qual   (ext_qual),
    .status     (status),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr)
);

// File: tb/test_smi_sci_aggregator.sv
module test_smi_sci_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int QC   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] evt_in = '0;
    logic ext_sci_req = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [NSRC:0] reg_wdata = '0;
    logic [NSRC:0] reg_rdata;
    logic sci_out, smi_msg;

    int n_chk = 0, n_fail = 0, smi_total = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_sci_aggregator #(.NUM_SRC(NSRC), .CLK_KHZ(200)) i_smi_sci_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .ext_sci_req(ext_sci_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sci_out(sci_out), .smi_msg(smi_msg)
    );

    always @(posedge clk) if (rst_n && smi_msg) smi_total++;

    typedef struct packed {
        logic       wr;
        logic [1:0] addr;
        logic [8:0] data;
        logic [7:0] evt;
        logic       e_sci;
        logic [3:0] e_smi;
        logic [8:0] e_sts;
    } step_t;

    // addr 0 status, 1 enable, 2 control {eos, global, route}
    localparam step_t TBL [18] = '{
        '{1'b1, 2'd1, 9'h1FF, 8'h00, 1'b0, 4'd0, 9'h000},
        '{1'b0, 2'd0, 9'h000, 8'h04, 1'b0, 4'd0, 9'h004}, // R6 global off
        '{1'b1, 2'd2, 9'h002, 8'h04, 1'b0, 4'd1, 9'h004}, // R1
        '{1'b0, 2'd0, 9'h000, 8'h0C, 1'b0, 4'd1, 9'h00C}, // R2
        '{1'b1, 2'd0, 9'h00C, 8'h0C, 1'b0, 4'd1, 9'h000}, // R10 clear
        '{1'b1, 2'd2, 9'h006, 8'h0C, 1'b0, 4'd1, 9'h000}, // R3 nothing pending
        '{1'b0, 2'd0, 9'h000, 8'h1C, 1'b0, 4'd2, 9'h010}, // R5 dual to SMI
        '{1'b1, 2'd0, 9'h010, 8'h1C, 1'b0, 4'd2, 9'h000},
        '{1'b1, 2'd2, 9'h007, 8'h1C, 1'b0, 4'd2, 9'h000},
        '{1'b0, 2'd0, 9'h000, 8'h3C, 1'b1, 4'd2, 9'h020}, // R5 dual to SCI
        '{1'b0, 2'd0, 9'h000, 8'h3D, 1'b1, 4'd2, 9'h021}, // R8 SCI-only, route 1
        '{1'b1, 2'd0, 9'h020, 8'h3D, 1'b1, 4'd2, 9'h001}, // R4 still held
        '{1'b1, 2'd0, 9'h001, 8'h3D, 1'b0, 4'd2, 9'h000}, // R4 released
        '{1'b1, 2'd2, 9'h002, 8'h3F, 1'b1, 4'd2, 9'h002}, // R7 release, route 0
        '{1'b1, 2'd0, 9'h002, 8'h3F, 1'b0, 4'd2, 9'h000},
        '{1'b0, 2'd0, 9'h000, 8'h3E, 1'b0, 4'd2, 9'h000},
        '{1'b0, 2'd0, 9'h000, 8'h3F, 1'b0, 4'd2, 9'h001}, // R8 SCI-only, route 0
        '{1'b1, 2'd0, 9'h001, 8'h3F, 1'b0, 4'd2, 9'h000}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_step(input logic wr, input logic [1:0] addr,
                           input logic [8:0] data, input logic [7:0] evt);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = data; evt_in = evt;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [1:0] addr, output logic [8:0] val);
        reg_addr = addr;
        #1 val = reg_rdata;
        reg_addr = 2'd0;
        #1;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            finish_run();
        end
    end

    initial begin
        logic [8:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(sci_out == 1'b0, "R11 sci", sci_out, 0);
        chk(smi_msg == 1'b0, "R11 smi", smi_msg, 0);
        read_reg(2'd0, v); chk(v == 9'h000, "R11 status", v, 0);
        read_reg(2'd1, v); chk(v == 9'h000, "R11 enable", v, 0);
        read_reg(2'd2, v); chk(v == 9'h004, "R11 control", v, 4);

        for (int i = 0; i < 18; i++) begin
            do_step(TBL[i].wr, TBL[i].addr, TBL[i].data, TBL[i].evt);
            chk(sci_out == TBL[i].e_sci, $sformatf("R4/R5/R7/R8 step %0d sci", i), sci_out, TBL[i].e_sci);
            chk(smi_total == int'(TBL[i].e_smi), $sformatf("R1/R2/R6 step %0d smi", i), smi_total, TBL[i].e_smi);
            read_reg(2'd0, v);
            chk(v == TBL[i].e_sts, $sformatf("R10 step %0d status", i), v, TBL[i].e_sts);
        end

        // R10 set and clear in one cycle: set wins; bit6 dual routes to SMI (R1)
        do_step(1'b1, 2'd0, 9'h040, 8'h7F);
        read_reg(2'd0, v); chk(v == 9'h040, "R10 set wins", v, 9'h040);
        chk(smi_total == 3, "R1 message", smi_total, 3);
        read_reg(2'd2, v); chk(v[2] == 1'b0, "R1 eos cleared", v[2], 0);

        // R3 re-arm with pending status
        do_step(1'b1, 2'd2, 9'h006, 8'h7F);
        chk(smi_total == 4, "R3 re-delivery", smi_total, 4);
        read_reg(2'd2, v); chk(v[2] == 1'b0, "R3 eos after re-delivery", v[2], 0);
        do_step(1'b1, 2'd0, 9'h040, 8'h7F);
        do_step(1'b1, 2'd2, 9'h006, 8'h7F);
        chk(smi_total == 4, "R3 no pending", smi_total, 4);
        read_reg(2'd2, v); chk(v[2] == 1'b1, "R3 eos stays armed", v[2], 1);

        // R9 qualifier: 19 edges rejected, longer accepted
        do_step(1'b1, 2'd2, 9'h007, 8'h7F);
        @(negedge clk); ext_sci_req = 1'b1;
        repeat (QC - 1) @(posedge clk);
        @(negedge clk); ext_sci_req = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        read_reg(2'd0, v); chk(v == 9'h000, "R9 short pulse status", v, 0);
        chk(sci_out == 1'b0, "R9 short pulse sci", sci_out, 0);
        ext_sci_req = 1'b1;
        repeat (QC + 5) @(posedge clk);
        @(negedge clk); ext_sci_req = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        read_reg(2'd0, v); chk(v == 9'h100, "R9 long pulse status", v, 9'h100);
        chk(sci_out == 1'b1, "R9 long pulse sci", sci_out, 1);
        do_step(1'b1, 2'd0, 9'h100, 8'h7F);
        chk(sci_out == 1'b0, "R4 cleared external", sci_out, 0);
        chk(smi_total == 4, "R5 external routed to SCI", smi_total, 4);

        done = 1'b1;
        finish_run();
    end
endmodule